// File: doc/BRIEF.md
# Streaming 3x3 Vertical-Gradient Convolver

This block takes image pixels in raster order, one per handshake, and produces a signed vertical-gradient value for every pixel whose full 3x3 neighbourhood lies inside the frame. Rows are treated as one continuous stream, with each row following the previous one. A shift-register history keeps the incoming pixel plus the 2W+2 pixels before it, which is exactly the (K-1)*W+K span a 3x3 window needs. The nine window taps are read at fixed offsets, so there is no address logic. The taps are weighted by the constant kernel: -1, -2, -1 on the oldest row, zero on the middle row and +1, +2, +1 on the newest row.

A sideband flag that travels with a pixel marks it as position (0,0) of a new frame. Position counters also wrap by themselves after IMG_H rows of IMG_W pixels. No result is produced for the outer one-pixel ring of the frame. The downstream ready signal throttles the whole stream: when it is low, nothing shifts and the output holds.

Top module: `grad3x3_stream`

## Requirements
- R1: After reset, out_valid is 0 and out_grad is 0.
- R2: Take an accepted pixel at row r, column c (origin 0,0, row-major) with r>=2 and c>=2, and let P(y,x) be the pixel at row y, column x. On the next clock edge out_valid rises and out_grad carries (P(r,c-2)+2P(r,c-1)+P(r,c)) - (P(r-2,c-2)+2P(r-2,c-1)+P(r-2,c)), as a two's-complement value. That result belongs to the centre pixel (r-1,c-1).
- R3: While fewer than 2W+3 pixels of the current frame have been accepted, an accepted pixel yields out_valid 0 on the next edge.
- R4: An accepted pixel in column 0 or 1 of any row yields out_valid 0 on the next edge, so the left and right border columns produce no output.
- R5: in_ready equals out_ready in the same cycle.
- R6: In a cycle with out_ready 0, no pixel is accepted, and out_valid and out_grad keep their values across the next edge.
- R7: A pixel accepted with in_sof 1 is placed at (0,0), whatever position came before it. The first result after it follows the 2W+3rd pixel of the new frame.
- R8: After IMG_H rows the position returns to (0,0) without in_sof, and a full new frame of border suppression follows.
- R9: The 11-bit signed output represents the extremes +1020 and -1020 exactly.
- R10: A cycle with out_ready 1 and in_valid 0 makes out_valid 0 on the next edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Pixel offered |
| in_ready | output | 1 | Pixel can be taken (mirrors out_ready) |
| in_pix | input | 8 | Unsigned pixel value |
| in_sof | input | 1 | This pixel starts a new frame at (0,0) |
| out_valid | output | 1 | out_grad holds a result |
| out_ready | input | 1 | Downstream takes the result; also stalls the input |
| out_grad | output | 11 | Signed vertical gradient |

## Verification
The hardest situation to reach from the ports is a frame restart that lands in the middle of a row, with older pixels still in the history. It is followed by a stretch where stale and fresh pixels share the history but must never be combined. The stimulus drives a partial frame, then raises in_sof and runs the next frame to completion. The stimulus also runs two frames back to back with no flag, to reach the wrap on the counters. Random stalls and idle cycles are woven through to catch any shift or result that slips through while ready is low. Directed frames of all-0 and all-255 rows push the output to both ends of its range.

// File: rtl/grad_pkg.sv
package grad_pkg;

    localparam int PIX_W  = 8;
    localparam int GRAD_W = 11;
    localparam int KSIZE  = 3;
    localparam int NTAPS  = KSIZE * KSIZE;

    // Weight for a tap dr rows older and dc columns older than the newest pixel.
    function automatic int kern_coef(input int dr, input int dc);
        int mag;
        mag = (dc == 1) ? 2 : 1;
        if (dr == 0)
            return mag;
        else if (dr == KSIZE - 1)
            return -mag;
        return 0;
    endfunction

endpackage

// File: rtl/grad_linebuf.sv
module grad_linebuf
    import grad_pkg::*;
#(
    parameter int IMG_W = 16
) (
    input  logic                              clk,
    input  logic                              rst_n,
    input  logic                              shift_en,
    input  logic [PIX_W-1:0]                  pix_in,
    output logic [NTAPS-1:0][PIX_W-1:0]       taps
);
    // Stored history; together with pix_in, (K-1)*W+K pixels are in flight.
    localparam int DEPTH = (KSIZE - 1) * IMG_W + KSIZE - 1;

    typedef struct packed {
        logic [DEPTH-1:0][PIX_W-1:0] mem;
    } lb_state_t;

    lb_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (shift_en) begin
            st_d.mem[0] = pix_in;
            for (int i = 1; i < DEPTH; i++)
                st_d.mem[i] = st_q.mem[i-1];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            st_q <= '0;
        else
            st_q <= st_d;
    end

    // Fixed tap positions: offset dr*W+dc from the newest pixel.
    for (genvar dr = 0; dr < KSIZE; dr++) begin : g_row
        for (genvar dc = 0; dc < KSIZE; dc++) begin : g_col
            localparam int OFF = dr * IMG_W + dc;
            if (OFF == 0) begin : g_newest
                assign taps[dr*KSIZE+dc] = pix_in;
            end else begin : g_stored
                assign taps[dr*KSIZE+dc] = st_q.mem[OFF-1];
            end
        end
    end

    AST_HISTORY_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
        !shift_en |=> $stable(st_q)); // R6

    AST_NEWEST_ENTERS: assert property (@(posedge clk) disable iff (!rst_n)
        shift_en |=> st_q.mem[0] == $past(pix_in)); // R2

endmodule

// File: rtl/grad_pos.sv
module grad_pos #(
    parameter int IMG_W = 16,
    parameter int IMG_H = 8
) (
    input  logic clk,
    input  logic rst_n,
    input  logic step,
    input  logic sof,
    output logic win_ok
);
    localparam int COL_W = (IMG_W > 1) ? $clog2(IMG_W) : 1;
    localparam int ROW_W = (IMG_H > 1) ? $clog2(IMG_H) : 1;
    localparam logic [COL_W-1:0] COL_LAST = COL_W'(IMG_W - 1);
    localparam logic [ROW_W-1:0] ROW_LAST = ROW_W'(IMG_H - 1);
    localparam logic [COL_W-1:0] COL_MIN  = COL_W'(2);
    localparam logic [ROW_W-1:0] ROW_MIN  = ROW_W'(2);

    typedef struct packed {
        logic [COL_W-1:0] col;
        logic [ROW_W-1:0] row;
    } pos_t;

    pos_t st_d, st_q;
    pos_t cur;

    always_comb begin
        cur    = sof ? '0 : st_q;
        win_ok = (cur.row >= ROW_MIN) && (cur.col >= COL_MIN);
        st_d   = st_q;
        if (step) begin
            if (cur.col == COL_LAST) begin
                st_d.col = '0;
                st_d.row = (cur.row == ROW_LAST) ? '0 : cur.row + 1'b1;
            end else begin
                st_d.col = cur.col + 1'b1;
                st_d.row = cur.row;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            st_q <= '0;
        else
            st_q <= st_d;
    end

    AST_POS_IN_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.col <= COL_LAST) && (st_q.row <= ROW_LAST)); // R8

    AST_SOF_RESTART: assert property (@(posedge clk) disable iff (!rst_n)
        (step && sof) |=> (st_q.row == '0) && (st_q.col == COL_W'(IMG_W > 1 ? 1 : 0))); // R7

endmodule

// File: rtl/grad_mac.sv
module grad_mac
    import grad_pkg::*;
(
    input  logic [NTAPS-1:0][PIX_W-1:0] taps,
    output logic signed [GRAD_W-1:0]    grad
);
    int acc;

    always_comb begin
        acc = 0;
        for (int dr = 0; dr < KSIZE; dr++)
            for (int dc = 0; dc < KSIZE; dc++)
                acc = acc + kern_coef(dr, dc) * int'(taps[dr*KSIZE+dc]);
        grad = GRAD_W'(acc);
    end

    always_comb begin
        AST_NO_OVERFLOW: assert (acc >= -1020 && acc <= 1020); // R9
    end

endmodule

// File: rtl/grad3x3_stream.sv
module grad3x3_stream
    import grad_pkg::*;
#(
    parameter int IMG_W = 16,
    parameter int IMG_H = 8
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     in_valid,
    output logic                     in_ready,
    input  logic [PIX_W-1:0]         in_pix,
    input  logic                     in_sof,
    output logic                     out_valid,
    input  logic                     out_ready,
    output logic signed [GRAD_W-1:0] out_grad
);
    localparam int FILL  = (KSIZE - 1) * IMG_W + KSIZE;
    localparam int CNT_W = $clog2(FILL + 1);

    typedef struct packed {
        logic                     vld;
        logic signed [GRAD_W-1:0] grad;
    } out_t;

    out_t st_d, st_q;
    logic accept;
    logic win_ok;
    logic signed [GRAD_W-1:0] mac_grad;
    logic [NTAPS-1:0][PIX_W-1:0] taps;

    assign in_ready = out_ready;
    assign accept   = in_valid && out_ready;

    grad_linebuf #(.IMG_W(IMG_W)) u_linebuf (
        .clk      (clk),
        .rst_n    (rst_n),
        .shift_en (accept),
        .pix_in   (in_pix),
        .taps     (taps)
    );

    grad_pos #(.IMG_W(IMG_W), .IMG_H(IMG_H)) u_pos (
        .clk    (clk),
        .rst_n  (rst_n),
        .step   (accept),
        .sof    (in_sof),
        .win_ok (win_ok)
    );

    grad_mac u_mac (
        .taps (taps),
        .grad (mac_grad)
    );

    always_comb begin
        st_d = st_q;
        if (out_ready) begin
            st_d.vld = accept && win_ok;
            if (accept && win_ok)
                st_d.grad = mac_grad;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            st_q <= '0;
        else
            st_q <= st_d;
    end

    assign out_valid = st_q.vld;
    assign out_grad  = st_q.grad;

    // Pixels accepted since the last frame start, saturating at FILL.
    logic [CNT_W-1:0] fill_q;
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            fill_q <= '0;
        else if (accept) begin
            if (in_sof)
                fill_q <= CNT_W'(1);
            else if (fill_q < CNT_W'(FILL))
                fill_q <= fill_q + 1'b1;
        end
    end

    AST_NO_EARLY_RESULT: assert property (@(posedge clk) disable iff (!rst_n)
        (accept && win_ok) |-> (!in_sof && fill_q >= CNT_W'(FILL - 1))); // R3

    AST_STALL_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        !out_ready |=> (out_valid == $past(out_valid)) && $stable(out_grad)); // R6

    AST_IDLE_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        (out_ready && !in_valid) |=> !out_valid); // R10

    AST_RESULT_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> (out_grad >= -1020 && out_grad <= 1020)); // R9

endmodule

// File: tb/grad3x3_stream_tb_top.sv
module grad3x3_stream_tb_top;
    localparam int W = 6;
    localparam int H = 5;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic in_valid = 1'b0;
    logic in_ready;
    logic [7:0] in_pix = '0;
    logic in_sof = 1'b0;
    logic out_valid;
    logic out_ready = 1'b0;
    logic signed [10:0] out_grad;

    always #5 clk = ~clk;

    grad3x3_stream #(.IMG_W(W), .IMG_H(H)) dut_i (
        .clk(clk), .rst_n(rst_n),
        .in_valid(in_valid), .in_ready(in_ready), .in_pix(in_pix), .in_sof(in_sof),
        .out_valid(out_valid), .out_ready(out_ready), .out_grad(out_grad)
    );

    int checks = 0;
    int errors = 0;
    int img [H][W];
    int mr = 0, mc = 0;
    bit have_exp = 0;
    bit e_valid = 0;
    int e_grad = 0;
    string e_tag = "";

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic check_out();
        if (have_exp) begin
            check(out_valid == e_valid, e_tag, int'(out_valid), int'(e_valid));
            if (e_valid)
                check(int'(out_grad) == e_grad, e_tag, int'(out_grad), e_grad);
        end
    endtask

    task automatic step(input bit v, input logic [7:0] p, input bit s, input bit r,
                        input string t);
        @(negedge clk);
        check_out();
        in_valid = v; in_pix = p; in_sof = s; out_ready = r;
        #1;
        check(in_ready == r, "R5", int'(in_ready), int'(r));
        if (!r) begin
            e_tag = "R6";
        end else if (!v) begin
            e_valid = 0;
            e_tag = "R10";
        end else begin
            if (s) begin mr = 0; mc = 0; end
            img[mr][mc] = int'(p);
            e_valid = (mr >= 2) && (mc >= 2);
            if (e_valid) begin
                e_grad = img[mr][mc-2] + 2*img[mr][mc-1] + img[mr][mc]
                       - img[mr-2][mc-2] - 2*img[mr-2][mc-1] - img[mr-2][mc];
                e_tag = (e_grad == 1020 || e_grad == -1020) ? "R9" : "R2";
            end else begin
                e_tag = (mr * W + mc < 2*W + 2) ? "R3" : "R4";
            end
            if (mc == W-1) begin
                mc = 0;
                mr = (mr == H-1) ? 0 : mr + 1;
            end else begin
                mc = mc + 1;
            end
        end
        if (t != "") e_tag = t;
        have_exp = 1;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        void'($urandom(32'h5EED));
        repeat (3) @(posedge clk);
        @(negedge clk);
        check(out_valid == 1'b0, "R1", int'(out_valid), 0);
        check(out_grad == '0, "R1", int'(out_grad), 0);
        rst_n = 1'b1;

        // Extremes: rows 0,255,255,0,0 -> +1020 on row 2, -1020 on row 3 (R9)
        for (int y = 0; y < H; y++)
            for (int x = 0; x < W; x++)
                step(1, (y == 1 || y == 2) ? 8'hFF : 8'h00, (y == 0 && x == 0), 1, "");

        // Partial frame then mid-row restart (R7)
        for (int i = 0; i < 9; i++) step(1, 8'($urandom), 0, 1, "");
        for (int i = 0; i < W*H; i++) step(1, 8'($urandom), (i == 0), 1, "R7");

        // Self-wrap: two frames without in_sof (R8)
        for (int i = 0; i < 2*W*H; i++) step(1, 8'($urandom), 0, 1, "R8");

        // Idle and stall corners (R10, R6)
        step(0, 8'h00, 0, 1, "R10");
        step(1, 8'h7F, 0, 0, "R6");
        step(1, 8'h11, 0, 0, "R6");

        // Random traffic with stalls, gaps and rare restarts
        for (int i = 0; i < 2000; i++)
            step(($urandom % 100) < 85, 8'($urandom), ($urandom % 250) == 0,
                 ($urandom % 100) < 80, "");

        @(negedge clk);
        check_out();
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule